// File: doc/BRIEF.md
# Pluggable Transceiver Media Classifier

This controller decides how a gigabit port should talk to the optical or copper module in its cage. On a start pulse it takes over two shared controls: it turns on the two-wire management bus and releases the cage power-down line. It then issues byte reads through an external two-wire access engine. The first read fetches the module identifier and the second fetches the Ethernet compliance byte. From these bytes it chooses one of two media types, internal SerDes or copper, and sets or clears an SGMII-active flag.

When the sequence ends, the two shared controls go back to the values the surrounding logic presents on the pass-through inputs. A one-cycle done pulse marks the end. The verdict and the fault code stay on the outputs until the next start.

An identifier read can fail. The controller retries it after a back-off interval measured in milliseconds of the system clock. When the module cannot be classified, the controller still produces a usable media setting, taken from a strap that says whether the port was wired for SGMII.

Top module: `xcvr_media_classifier`

## Requirements
- R1: After reset, done, rd_req, media_serdes, sgmii_on and fault are all 0, and i2c_en_o and cage_pwrdn_o follow i2c_en_in and cage_pwrdn_in.
- R2: From the start pulse until done, i2c_en_o is 1 and cage_pwrdn_o is 0. From the cycle after done they again equal i2c_en_in and cage_pwrdn_in.
- R3: The identifier is read at offset 0x00. A read answered with rd_err is retried, for at most ID_TRIES attempts in all (3 by default). Successive attempts are at least (CLK_HZ/1000)*WAIT_MS cycles apart. When every attempt fails, the fault is 1 (read error). A failed compliance-byte read also gives fault 1, and it is not retried.
- R4: Only the identifier values 0x02 and 0x03 are accepted. Any other value gives fault 2 (bad identifier), and the compliance byte is not read.
- R5: The compliance byte is read at offset 0x06. If bit 1 or bit 0 is set, the result is media_serdes=1 and sgmii_on=0, whatever the other bits are.
- R6: Otherwise, if bit 5 or bit 4 is set, the result is media_serdes=1 and sgmii_on=1, whatever bit 3 is.
- R7: Otherwise, if bit 3 is set, the result is media_serdes=0 (copper) and sgmii_on=1.
- R8: If none of bits 0, 1, 3, 4 and 5 is set, the fault is 3 (unrecognised module). This holds even when bits 2, 6 or 7 are set.
- R9: On any nonzero fault, the outputs fall back as follows: with strap_sgmii=1 they are media_serdes=0 and sgmii_on=1; with strap_sgmii=0 they are media_serdes=1 and sgmii_on=0.
- R10: done is high for exactly one cycle per sequence. The outputs hold their values until the next accepted start. A start that arrives during a sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a classification sequence (single-cycle pulse) |
| strap_sgmii | input | 1 | Board strap requesting SGMII; selects the fallback |
| i2c_en_in | input | 1 | Two-wire enable value used outside a sequence |
| cage_pwrdn_in | input | 1 | Cage power-down value used outside a sequence |
| i2c_en_o | output | 1 | Two-wire bus enable to the port |
| cage_pwrdn_o | output | 1 | Cage power-down control |
| rd_req | output | 1 | One-cycle byte-read request to the access engine |
| rd_addr | output | 8 | Byte offset in the module ID memory |
| rd_done | input | 1 | Engine completion strobe |
| rd_err | input | 1 | Engine error, valid with rd_done |
| rd_data | input | 8 | Read byte, valid with rd_done |
| done | output | 1 | Sequence finished (one cycle) |
| media_serdes | output | 1 | 1 = internal SerDes, 0 = copper |
| sgmii_on | output | 1 | SGMII active |
| fault | output | 2 | 0 none, 1 read error, 2 bad identifier, 3 unrecognised |

## Verification
The bench builds the block with CLK_HZ=1000 and WAIT_MS=100, so the back-off interval is 100 cycles. At that length the bench can run a full exhaustion of three identifier attempts and measure the spacing between the attempts. ID_TRIES keeps its default of 3, so both cases are covered: success on the last allowed attempt, and failure after it. The behavioural engine model in the bench can fail a chosen number of identifier reads, or fail the compliance read. With it, every priority level, every fault code and both strap fallbacks are reached.

// File: rtl/xcvr_media_pkg.sv
package xcvr_media_pkg;

    typedef enum logic [1:0] {
        FAULT_NONE    = 2'd0,
        FAULT_READ    = 2'd1,
        FAULT_IDENT   = 2'd2,
        FAULT_UNKNOWN = 2'd3
    } fault_e;

    typedef struct packed {
        logic   serdes;
        logic   sgmii;
        fault_e fault;
    } verdict_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID_REQ,
        ST_ID_WAIT,
        ST_BACKOFF,
        ST_FL_REQ,
        ST_FL_WAIT,
        ST_FINISH
    } seq_e;

    localparam logic [7:0] OFS_IDENT      = 8'h00;
    localparam logic [7:0] OFS_COMPLY     = 8'h06;
    localparam logic [7:0] IDENT_SOLDERED = 8'h02;
    localparam logic [7:0] IDENT_PLUGGED  = 8'h03;

    // compliance byte bit positions
    localparam int BIT_GIG_SX  = 0;
    localparam int BIT_GIG_LX  = 1;
    localparam int BIT_GIG_T   = 3;
    localparam int BIT_FAST_LX = 4;
    localparam int BIT_FAST_FX = 5;

    function automatic logic ident_ok(input logic [7:0] id);
        return (id == IDENT_SOLDERED) || (id == IDENT_PLUGGED);
    endfunction

    // outcome used whenever the module cannot be classified
    function automatic verdict_t fallback(input logic strap, input fault_e why);
        verdict_t v;
        v.serdes = !strap;
        v.sgmii  = strap;
        v.fault  = why;
        return v;
    endfunction

endpackage

// File: rtl/xcvr_backoff_timer.sv
module xcvr_backoff_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= CNT_W'(CYCLES - 1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    // a freshly loaded wait never ends in the next cycle (CYCLES >= 2)
    assert_backoff_min_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> !expired);

endmodule

// File: rtl/xcvr_flag_decode.sv
module xcvr_flag_decode
    import xcvr_media_pkg::*;
(
    input  logic [7:0] flags,
    input  logic       strap,
    output verdict_t   verdict
);
    always_comb begin
        verdict = fallback(strap, FAULT_UNKNOWN);
        if (flags[BIT_GIG_LX] || flags[BIT_GIG_SX]) begin
            verdict = '{serdes: 1'b1, sgmii: 1'b0, fault: FAULT_NONE};
        end else if (flags[BIT_FAST_FX] || flags[BIT_FAST_LX]) begin
            verdict = '{serdes: 1'b1, sgmii: 1'b1, fault: FAULT_NONE};
        end else if (flags[BIT_GIG_T]) begin
            verdict = '{serdes: 1'b0, sgmii: 1'b1, fault: FAULT_NONE};
        end
    end

endmodule

// File: rtl/xcvr_media_classifier.sv
module xcvr_media_classifier
    import xcvr_media_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int WAIT_MS  = 100,
    parameter int ID_TRIES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       strap_sgmii,
    input  logic       i2c_en_in,
    input  logic       cage_pwrdn_in,
    output logic       i2c_en_o,
    output logic       cage_pwrdn_o,
    output logic       rd_req,
    output logic [7:0] rd_addr,
    input  logic       rd_done,
    input  logic       rd_err,
    input  logic [7:0] rd_data,
    output logic       done,
    output logic       media_serdes,
    output logic       sgmii_on,
    output logic [1:0] fault
);
    localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;
    localparam int TRY_W    = $clog2(ID_TRIES + 1);

    seq_e             state;
    logic [TRY_W-1:0] fails;
    verdict_t         result;
    verdict_t         decoded;
    logic             tmr_load;
    logic             tmr_expired;
    logic             busy;
    logic             last_try;

    xcvr_backoff_timer #(.CYCLES(WAIT_CYC)) u_backoff (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    xcvr_flag_decode u_decode (
        .flags   (rd_data),
        .strap   (strap_sgmii),
        .verdict (decoded)
    );

    assign busy     = (state != ST_IDLE);
    assign last_try = (fails == TRY_W'(ID_TRIES - 1));
    assign tmr_load = (state == ST_ID_WAIT) && rd_done && rd_err && !last_try;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            fails  <= '0;
            result <= '{serdes: 1'b0, sgmii: 1'b0, fault: FAULT_NONE};
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ID_REQ;
                    fails <= '0;
                end
                ST_ID_REQ: state <= ST_ID_WAIT;
                ST_ID_WAIT: if (rd_done) begin
                    if (rd_err) begin
                        if (last_try) begin
                            result <= fallback(strap_sgmii, FAULT_READ);
                            state  <= ST_FINISH;
                        end else begin
                            fails <= fails + 1'b1;
                            state <= ST_BACKOFF;
                        end
                    end else if (!ident_ok(rd_data)) begin
                        result <= fallback(strap_sgmii, FAULT_IDENT);
                        state  <= ST_FINISH;
                    end else begin
                        state <= ST_FL_REQ;
                    end
                end
                ST_BACKOFF: if (tmr_expired) state <= ST_ID_REQ;
                ST_FL_REQ:  state <= ST_FL_WAIT;
                ST_FL_WAIT: if (rd_done) begin
                    result <= rd_err ? fallback(strap_sgmii, FAULT_READ) : decoded;
                    state  <= ST_FINISH;
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req       = (state == ST_ID_REQ) || (state == ST_FL_REQ);
    assign rd_addr      = (state == ST_FL_REQ) ? OFS_COMPLY : OFS_IDENT;
    assign done         = (state == ST_FINISH);
    assign i2c_en_o     = busy ? 1'b1 : i2c_en_in;
    assign cage_pwrdn_o = busy ? 1'b0 : cage_pwrdn_in;
    assign media_serdes = result.serdes;
    assign sgmii_on     = result.sgmii;
    assign fault        = result.fault;

    assert_ctrl_held_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (i2c_en_o && !cage_pwrdn_o));

    assert_ctrl_restored_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> (i2c_en_o == i2c_en_in) && (cage_pwrdn_o == cage_pwrdn_in));

    assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    assert_try_bound_R3: assert property (@(posedge clk) disable iff (rst)
        fails < TRY_W'(ID_TRIES));

    assert_copper_sgmii_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !media_serdes) |-> sgmii_on);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({media_serdes, sgmii_on, fault}));

endmodule

// File: tb/test_xcvr_media_classifier.sv
`timescale 1ns/1ps
module test_xcvr_media_classifier;

    localparam int CLK_HZ   = 1000;
    localparam int WAIT_MS  = 100;
    localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] id;
        logic [7:0] flags;
        logic [1:0] id_fails;
        logic       fl_err;
        logic       strap;
        logic       exp_serdes;
        logic       exp_sgmii;
        logic [1:0] exp_fault;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd5, 8'h03, 8'h02, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R5 gig LX
        '{4'd5, 8'h02, 8'h01, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R5 gig SX, soldered id
        '{4'd5, 8'h03, 8'h21, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R5 beats FX
        '{4'd6, 8'h03, 8'h20, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0}, // R6 fast FX
        '{4'd6, 8'h03, 8'h10, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0}, // R6 fast LX
        '{4'd6, 8'h03, 8'h18, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0}, // R6 beats T
        '{4'd7, 8'h03, 8'h08, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0}, // R7 copper
        '{4'd8, 8'h03, 8'hC4, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3}, // R8 R9 strap 0
        '{4'd8, 8'h03, 8'hC4, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3}, // R8 R9 strap 1
        '{4'd4, 8'h01, 8'h02, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}, // R4 bad id
        '{4'd4, 8'h00, 8'h02, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2}, // R4 empty id
        '{4'd3, 8'h03, 8'h08, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0}, // R3 last try ok
        '{4'd3, 8'h03, 8'h02, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1}, // R3 exhausted
        '{4'd3, 8'h03, 8'h08, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1}  // R3 flags read err
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       strap_sgmii = 1'b0;
    logic       i2c_en_in = 1'b0;
    logic       cage_pwrdn_in = 1'b1;
    logic       i2c_en_o, cage_pwrdn_o, rd_req, done, media_serdes, sgmii_on;
    logic [7:0] rd_addr;
    logic [1:0] fault;
    logic       rd_done = 1'b0;
    logic       rd_err = 1'b0;
    logic [7:0] rd_data = 8'h00;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic finished = 1'b0;

    // engine model state
    logic [7:0] cur_id = 8'h00;
    logic [7:0] cur_flags = 8'h00;
    int         cur_fails = 0;
    logic       cur_flerr = 1'b0;
    int         id_reads = 0;
    int         fl_reads = 0;
    int         bad_addr = 0;
    int         ctl_bad = 0;
    int         last_req = 0;
    int         min_gap = 1000000;
    int         max_gap = 0;
    int         lat = 0;
    logic [7:0] pend_addr = 8'h00;

    xcvr_media_classifier #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS), .ID_TRIES(3))
        i_xcvr_media_classifier (
        .clk(clk), .rst(rst), .start(start), .strap_sgmii(strap_sgmii),
        .i2c_en_in(i2c_en_in), .cage_pwrdn_in(cage_pwrdn_in),
        .i2c_en_o(i2c_en_o), .cage_pwrdn_o(cage_pwrdn_o),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
        .rd_err(rd_err), .rd_data(rd_data), .done(done),
        .media_serdes(media_serdes), .sgmii_on(sgmii_on), .fault(fault)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural two-wire access engine, answers two cycles after a request
    always @(negedge clk) begin
        rd_done = 1'b0;
        rd_err  = 1'b0;
        if (lat > 0) begin
            lat = lat - 1;
            if (lat == 0) begin
                rd_done = 1'b1;
                if (pend_addr == 8'h00) begin
                    id_reads = id_reads + 1;
                    rd_err   = (id_reads <= cur_fails);
                    rd_data  = cur_id;
                end else begin
                    fl_reads = fl_reads + 1;
                    rd_err   = cur_flerr;
                    rd_data  = cur_flags;
                end
            end
        end else if (rd_req) begin
            lat       = 2;
            pend_addr = rd_addr;
            if (rd_addr != 8'h00 && rd_addr != 8'h06) bad_addr = bad_addr + 1;
            if (!(i2c_en_o && !cage_pwrdn_o)) ctl_bad = ctl_bad + 1;
            if (rd_addr == 8'h00) begin
                if (id_reads > 0) begin
                    if (cyc - last_req < min_gap) min_gap = cyc - last_req;
                    if (cyc - last_req > max_gap) max_gap = cyc - last_req;
                end
                last_req = cyc;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(req, "done seen", {31'd0, done}, 32'd1);
    endtask

    task automatic launch(input vec_t v, input logic en_in, input logic pd_in);
        cur_id = v.id; cur_flags = v.flags; cur_fails = int'(v.id_fails);
        cur_flerr = v.fl_err; id_reads = 0; fl_reads = 0; ctl_bad = 0;
        bad_addr = 0; min_gap = 1000000; max_gap = 0;
        strap_sgmii = v.strap; i2c_en_in = en_in; cage_pwrdn_in = pd_in;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1", "media/sgmii/fault", {28'd0, media_serdes, sgmii_on, fault}, 32'd0);
        chk("R1", "controls pass", {30'd0, i2c_en_o, cage_pwrdn_o}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            vec_t  v = VECS[i];
            string rq = $sformatf("R%0d", v.req);
            int    exp_id = (int'(v.id_fails) + 1 > 3) ? 3 : int'(v.id_fails) + 1;
            int    exp_fl = (v.exp_fault == 2'd0 || v.exp_fault == 2'd3 || v.fl_err) ? 1 : 0;
            launch(v, i[0], ~i[1]);
            wait_done(rq);
            chk(rq, "media_serdes", {31'd0, media_serdes}, {31'd0, v.exp_serdes});
            chk(rq, "sgmii_on", {31'd0, sgmii_on}, {31'd0, v.exp_sgmii});
            chk(rq, "fault", {30'd0, fault}, {30'd0, v.exp_fault});
            if (v.exp_fault != 2'd0)
                chk("R9", "fallback", {30'd0, media_serdes, sgmii_on},
                    {30'd0, !v.strap, v.strap});
            chk("R3", "id reads", 32'(id_reads), 32'(exp_id));
            chk("R4", "flag reads", 32'(fl_reads), 32'(exp_fl));
            chk("R5", "read offsets", 32'(bad_addr), 32'd0);
            chk("R2", "controls during run", 32'(ctl_bad), 32'd0);
            if (v.id_fails != 2'd0) begin
                chk("R3", "retry gap lower", {31'd0, min_gap >= WAIT_CYC}, 32'd1);
                chk("R3", "retry gap upper", {31'd0, max_gap <= WAIT_CYC + 10}, 32'd1);
            end
            @(negedge clk);
            chk("R10", "done one cycle", {31'd0, done}, 32'd0);
            chk("R2", "controls restored", {30'd0, i2c_en_o, cage_pwrdn_o},
                {30'd0, i[0], ~i[1]});
        end

        // R10: start during a sequence is ignored, outputs then hold
        begin
            vec_t v = '{4'd7, 8'h03, 8'h08, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0};
            logic [3:0] snap;
            int   extra = 0;
            launch(v, 1'b0, 1'b1);
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done("R10");
            chk("R10", "single id read", 32'(id_reads), 32'd1);
            chk("R10", "single flag read", 32'(fl_reads), 32'd1);
            chk("R7", "copper verdict", {30'd0, media_serdes, sgmii_on}, 32'h1);
            snap = {media_serdes, sgmii_on, fault};
            repeat (30) begin
                @(negedge clk);
                if (done || rd_req) extra++;
            end
            chk("R10", "no restart", 32'(extra), 32'd0);
            chk("R10", "outputs held", {28'd0, media_serdes, sgmii_on, fault},
                {28'd0, snap});
        end

        summary();
    end

endmodule